// File: doc/BRIEF.md
# Paired-Clock Multi-Channel PWM Generator

This block produces a set of independent pulse-width-modulated outputs (eight by default) from one system clock. Neighbouring channels are grouped in twos. Each group shares a clock-setup word that chooses between two source tick streams and divides the chosen stream by a power of two. Every channel then divides that shared tick by its own prescaler. The result drives a period counter, which is compared against a programmable active count. The output level during the active phase is also programmable.

The two source clocks are stand-ins. They reach the block as single-cycle tick enables, `osc_tick` and `bus_tick`, in the system clock domain. All later clock stages are also tick enables, so the whole design sits in one clock domain. A plain address/data write port sets up the block, and a registered read port returns what was written.

Each channel has a pin value and a drive-enable. When a channel is switched off, its drive-enable falls, so the pad can float. New settings are used as soon as they are written, even in the middle of a period.

Top module: `pwm_pair_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every register to zero. It drives `pwm_out` and `pwm_oe` low and returns `rdata` to zero after the edge.
- R2: Register map, byte offsets on `addr`:
  - Group setup word for group p at 0x00+4p: bit 4 is the source (0 = `osc_tick`, 1 = `bus_tick`) and bits 3:0 are exponent M.
  - Enable word at 0x40: bit c belongs to channel c.
  - Gate word at 0x44: bit c belongs to channel c.
  - Control word for channel c at 0x80+8c: bit 8 is the active level and bits 7:0 are prescale K.
  - Period word for channel c at 0x84+8c: bits 31:16 are the entire count E and bits 15:0 are the active count A.
  - Unused bits and unmapped offsets read as zero. `rdata` shows, one cycle later, the register at the `addr` sampled on the previous edge.
- R3: Each group passes one tick of its selected source out of every 2^M. A free-running count of source ticks decides which ticks pass. Channels 2p and 2p+1 both use the ticks of group p.
- R4: While a channel is enabled and gated, its period counter advances once every K+1 group ticks.
- R5: The period counter runs from 0 up to E and then wraps to 0, so a period lasts E+1 advances. The channel is in its active phase while the count is below A.
- R6: If A is greater than E, the output stays at the active level for the whole period. If A is 0, the output stays at the inactive level.
- R7: With the active-level bit set to 1, the active phase drives `pwm_out` high and the inactive phase drives it low. With the bit at 0 the two levels swap.
- R8: While a channel's gate bit is clear, its prescaler and period counter hold their values, so the output level holds too.
- R9: While a channel's enable bit is clear:
  - its `pwm_oe` and `pwm_out` are low;
  - its prescaler and counter are held at 0, so it restarts with the active phase when enabled again.
- R10: Control and period writes take effect at once, without waiting for the end of the period. If the counter is at or above a newly written E, its next advance wraps it to 0.
- R11: `pwm_out` and `pwm_oe` are registered. They reflect the channel's count and settings as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | Tick enable standing in for the oscillator source |
| bus_tick | input | 1 | Tick enable standing in for the bus source |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte offset for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | NCH | Per-channel PWM level |
| pwm_oe | output | NCH | Per-channel drive-enable, low means high-impedance |

## Verification
The hardest case to reach from the ports is a period write that lands while the counter is already past the new entire count. In that case the wrap depends on `>=` rather than on an exact match. Reaching it needs three things together: the right group tick pattern, the right prescaler phase and the right write timing. A directed sequence runs a long period, waits until the count is well advanced, and then shrinks the period. Seeded random writes also land at random cycles across all channels while both source streams tick with random densities. A cycle-by-cycle reference model of the requirements checks every output and every read.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // register offsets (bytes)
  localparam int GRP_BASE   = 'h00;
  localparam int GRP_STRIDE = 4;
  localparam int EN_OFS     = 'h40;
  localparam int GATE_OFS   = 'h44;
  localparam int CH_BASE    = 'h80;
  localparam int CH_STRIDE  = 8;
  localparam int PER_OFS    = 4;
  // field positions
  localparam int SRC_BIT    = 4;
  localparam int POL_BIT    = 8;
  localparam int ENT_LSB    = 16;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int NGRP   = 4,
  parameter int PRE_W  = 8,
  parameter int CNT_W  = 16,
  parameter int EXP_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  output logic [NGRP-1:0]             grp_src,
  output logic [NGRP-1:0][EXP_W-1:0]  grp_exp,
  output logic [NCH-1:0]              ch_en,
  output logic [NCH-1:0]              ch_gate,
  output logic [NCH-1:0]              ch_pol,
  output logic [NCH-1:0][PRE_W-1:0]   ch_pre,
  output logic [NCH-1:0][CNT_W-1:0]   ch_ent,
  output logic [NCH-1:0][CNT_W-1:0]   ch_act
);
  logic [31:0] rd_nx;
  logic        unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_src <= '0;
      grp_exp <= '0;
      ch_en   <= '0;
      ch_gate <= '0;
      ch_pol  <= '0;
      ch_pre  <= '0;
      ch_ent  <= '0;
      ch_act  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(EN_OFS))   ch_en   <= wdata[NCH-1:0];
      if (addr == ADDR_W'(GATE_OFS)) ch_gate <= wdata[NCH-1:0];
      for (int p = 0; p < NGRP; p++) begin
        if (addr == ADDR_W'(GRP_BASE + GRP_STRIDE * p)) begin
          grp_exp[p] <= wdata[EXP_W-1:0];
          grp_src[p] <= wdata[SRC_BIT];
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (addr == ADDR_W'(CH_BASE + CH_STRIDE * c)) begin
          ch_pre[c] <= wdata[PRE_W-1:0];
          ch_pol[c] <= wdata[POL_BIT];
        end
        if (addr == ADDR_W'(CH_BASE + CH_STRIDE * c + PER_OFS)) begin
          ch_ent[c] <= wdata[ENT_LSB +: CNT_W];
          ch_act[c] <= wdata[CNT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_nx = '0;
    if (addr == ADDR_W'(EN_OFS))   rd_nx[NCH-1:0] = ch_en;
    if (addr == ADDR_W'(GATE_OFS)) rd_nx[NCH-1:0] = ch_gate;
    for (int p = 0; p < NGRP; p++) begin
      if (addr == ADDR_W'(GRP_BASE + GRP_STRIDE * p)) begin
        rd_nx[EXP_W-1:0] = grp_exp[p];
        rd_nx[SRC_BIT]   = grp_src[p];
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(CH_BASE + CH_STRIDE * c)) begin
        rd_nx[PRE_W-1:0] = ch_pre[c];
        rd_nx[POL_BIT]   = ch_pol[c];
      end
      if (addr == ADDR_W'(CH_BASE + CH_STRIDE * c + PER_OFS)) begin
        rd_nx[ENT_LSB +: CNT_W] = ch_ent[c];
        rd_nx[CNT_W-1:0]        = ch_act[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nx;
  end

  // R2: an enable write lands in the enable register on the next cycle
  p_enable_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(EN_OFS)) |=> ch_en == $past(wdata[NCH-1:0]));
endmodule

// File: rtl/pwm_clkdiv.sv
module pwm_clkdiv #(
  parameter int EXP_W = 4,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic             bus_tick,
  input  logic             src_bus,
  input  logic [EXP_W-1:0] div_exp,
  output logic             div_tick
);
  logic             src_tick;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_mask;

  always_comb begin
    src_tick = src_bus ? bus_tick : osc_tick;
    div_mask = (DIV_W'(1) << div_exp) - DIV_W'(1);
  end

  assign div_tick = src_tick && ((div_cnt & div_mask) == div_mask);

  always_ff @(posedge clk) begin
    if (rst)           div_cnt <= '0;
    else if (src_tick) div_cnt <= div_cnt + DIV_W'(1);
  end

  // R3: with M > 0 and unchanged settings, passed ticks are never back to back
  p_div_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (div_tick && div_exp != '0) ##1 ($stable(div_exp) && $stable(src_bus)) |-> !div_tick);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_tick,
  input  logic             ch_en,
  input  logic             ch_gate,
  input  logic             ch_pol,
  input  logic [PRE_W-1:0] pre_k,
  input  logic [CNT_W-1:0] ent_cnt,
  input  logic [CNT_W-1:0] act_cnt,
  output logic             pwm_out,
  output logic             pwm_oe
);
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] per_cnt;
  logic             step;
  logic             in_active;

  assign step      = ch_en && ch_gate && div_tick;
  assign in_active = per_cnt < act_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      per_cnt <= '0;
      pwm_out <= 1'b0;
      pwm_oe  <= 1'b0;
    end else begin
      pwm_oe  <= ch_en;
      pwm_out <= ch_en && (in_active ? ch_pol : !ch_pol);
      if (!ch_en) begin
        pre_cnt <= '0;
        per_cnt <= '0;
      end else if (step) begin
        if (pre_cnt >= pre_k) begin
          pre_cnt <= '0;
          per_cnt <= (per_cnt >= ent_cnt) ? '0 : per_cnt + CNT_W'(1);
        end else begin
          pre_cnt <= pre_cnt + PRE_W'(1);
        end
      end
    end
  end

  // R9: drive-enable follows the enable bit one cycle later
  p_oe_tracks_en_r9: assert property (@(posedge clk) disable iff (rst)
    ch_en |=> pwm_oe);
  // R9: a disabled channel is quiet and its count sits at zero
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !ch_en |=> (!pwm_oe && !pwm_out && per_cnt == '0));
  // R4: below the prescale count the period counter does not move
  p_prescale_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (step && pre_cnt < pre_k) |=> $stable(per_cnt));
  // R5: after an advance the count never exceeds the entire count
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (step && pre_cnt >= pre_k) |=> per_cnt <= $past(ent_cnt));
  // R8: gate cleared freezes both counters
  p_gate_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (ch_en && !ch_gate) |=> ($stable(per_cnt) && $stable(pre_cnt)));
  // R6: active count beyond the period gives a constant active level
  p_full_duty_r6: assert property (@(posedge clk) disable iff (rst)
    (ch_en && act_cnt > ent_cnt && per_cnt <= ent_cnt) |=> pwm_out == $past(ch_pol));
  // R6: zero active count gives a constant inactive level
  p_zero_duty_r6: assert property (@(posedge clk) disable iff (rst)
    (ch_en && act_cnt == '0) |=> pwm_out == !$past(ch_pol));
  // R7: during the active phase the output shows the programmed level
  p_active_level_r7: assert property (@(posedge clk) disable iff (rst)
    (ch_en && in_active) |=> pwm_out == $past(ch_pol));
  // R10: a count at or past a shrunken period wraps on its next advance
  p_shrink_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (step && pre_cnt >= pre_k && per_cnt >= ent_cnt) |=> per_cnt == '0);
endmodule

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl #(
  parameter int NCH    = 8,
  parameter int PRE_W  = 8,
  parameter int CNT_W  = 16,
  parameter int EXP_W  = 4,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              bus_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pwm_oe
);
  localparam int NGRP = (NCH + 1) / 2;

  logic [NGRP-1:0]            grp_src;
  logic [NGRP-1:0][EXP_W-1:0] grp_exp;
  logic [NGRP-1:0]            grp_tick;
  logic [NCH-1:0]             ch_en;
  logic [NCH-1:0]             ch_gate;
  logic [NCH-1:0]             ch_pol;
  logic [NCH-1:0][PRE_W-1:0]  ch_pre;
  logic [NCH-1:0][CNT_W-1:0]  ch_ent;
  logic [NCH-1:0][CNT_W-1:0]  ch_act;

  pwm_regs #(
    .NCH(NCH), .NGRP(NGRP), .PRE_W(PRE_W), .CNT_W(CNT_W),
    .EXP_W(EXP_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .grp_src(grp_src), .grp_exp(grp_exp),
    .ch_en(ch_en), .ch_gate(ch_gate), .ch_pol(ch_pol),
    .ch_pre(ch_pre), .ch_ent(ch_ent), .ch_act(ch_act)
  );

  for (genvar p = 0; p < NGRP; p++) begin : g_grp
    pwm_clkdiv #(.EXP_W(EXP_W), .DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_tick(bus_tick),
      .src_bus(grp_src[p]), .div_exp(grp_exp[p]), .div_tick(grp_tick[p])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .div_tick(grp_tick[c/2]),
      .ch_en(ch_en[c]), .ch_gate(ch_gate[c]), .ch_pol(ch_pol[c]),
      .pre_k(ch_pre[c]), .ent_cnt(ch_ent[c]), .act_cnt(ch_act[c]),
      .pwm_out(pwm_out[c]), .pwm_oe(pwm_oe[c])
    );
  end

  // R1: one cycle after reset every output is quiet and undriven
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pwm_oe == '0 && pwm_out == '0 && rdata == '0));
endmodule

// File: tb/tb_pwm_pair_ctrl.sv
module tb_pwm_pair_ctrl;
  localparam int NCH  = 8;
  localparam int NGRP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_tick = 1'b0;
  logic        bus_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm_out;
  logic [NCH-1:0] pwm_oe;

  pwm_pair_ctrl dut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_tick(bus_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always #10 clk = ~clk;   // 50 MHz

  int    nchk = 0;
  int    nfail = 0;
  bit    checking = 0;
  bit    done = 0;
  string cur_req = "R1";
  int    osc_pct = 50;
  int    bus_pct = 100;

  // reference state built from the requirements
  bit          m_src [NGRP];
  int          m_exp [NGRP];
  int          m_dcnt[NGRP];
  bit [NCH-1:0] m_en, m_gate, m_pol;
  int          m_k[NCH], m_ent[NCH], m_act[NCH], m_pc[NCH], m_cnt[NCH];
  bit [NCH-1:0] e_out, e_oe;
  bit [31:0]   e_rdata;

  function automatic bit [31:0] model_read(input bit [7:0] a);
    bit [31:0] r = 0;
    if (a == 8'h40) r = 32'(m_en);
    if (a == 8'h44) r = 32'(m_gate);
    for (int p = 0; p < NGRP; p++)
      if (a == 8'(4*p)) r = (32'(m_src[p]) << 4) | 32'(m_exp[p]);
    for (int c = 0; c < NCH; c++) begin
      if (a == 8'(128 + 8*c)) r = (32'(m_pol[c]) << 8) | 32'(m_k[c]);
      if (a == 8'(132 + 8*c)) r = (32'(m_ent[c]) << 16) | 32'(m_act[c]);
    end
    return r;
  endfunction

  task automatic model_write(input bit [7:0] a, input bit [31:0] d);
    if (a == 8'h40) m_en = d[NCH-1:0];
    if (a == 8'h44) m_gate = d[NCH-1:0];
    for (int p = 0; p < NGRP; p++)
      if (a == 8'(4*p)) begin m_src[p] = d[4]; m_exp[p] = int'(d[3:0]); end
    for (int c = 0; c < NCH; c++) begin
      if (a == 8'(128 + 8*c)) begin m_pol[c] = d[8]; m_k[c] = int'(d[7:0]); end
      if (a == 8'(132 + 8*c)) begin m_ent[c] = int'(d[31:16]); m_act[c] = int'(d[15:0]); end
    end
  endtask

  task automatic model_step();
    bit dt[NGRP];
    if (rst) begin
      for (int p = 0; p < NGRP; p++) begin m_src[p] = 0; m_exp[p] = 0; m_dcnt[p] = 0; end
      for (int c = 0; c < NCH; c++) begin
        m_k[c] = 0; m_ent[c] = 0; m_act[c] = 0; m_pc[c] = 0; m_cnt[c] = 0;
      end
      m_en = 0; m_gate = 0; m_pol = 0; e_out = 0; e_oe = 0; e_rdata = 0;
      return;
    end
    e_rdata = model_read(addr);
    for (int p = 0; p < NGRP; p++) begin
      bit s = m_src[p] ? bus_tick : osc_tick;
      int mask = (1 << m_exp[p]) - 1;
      dt[p] = s && ((m_dcnt[p] & mask) == mask);
      if (s) m_dcnt[p] = (m_dcnt[p] + 1) & 16'hFFFF;
    end
    for (int c = 0; c < NCH; c++) begin
      e_oe[c]  = m_en[c];
      e_out[c] = m_en[c] && ((m_cnt[c] < m_act[c]) ? m_pol[c] : !m_pol[c]);
      if (!m_en[c]) begin
        m_pc[c] = 0; m_cnt[c] = 0;
      end else if (dt[c/2] && m_gate[c]) begin
        if (m_pc[c] >= m_k[c]) begin
          m_pc[c]  = 0;
          m_cnt[c] = (m_cnt[c] >= m_ent[c]) ? 0 : m_cnt[c] + 1;
        end else m_pc[c] = m_pc[c] + 1;
      end
    end
    if (wr_en) model_write(addr, wdata);
  endtask

  always @(posedge clk) model_step();

  always @(negedge clk) begin
    osc_tick = ($urandom % 100) < osc_pct;
    bus_tick = ($urandom % 100) < bus_pct;
  end

  initial forever begin
    @(posedge clk); #5;
    if (checking && !done) begin
      nchk++;
      if (pwm_out !== e_out) begin
        nfail++;
        $display("FAIL %s/R11 pwm_out act=%b exp=%b at %0t", cur_req, pwm_out, e_out, $time);
      end
      nchk++;
      if (pwm_oe !== e_oe) begin
        nfail++;
        $display("FAIL %s/R9 pwm_oe act=%b exp=%b at %0t", cur_req, pwm_oe, e_oe, $time);
      end
      nchk++;
      if (rdata !== e_rdata) begin
        nfail++;
        $display("FAIL %s/R2 rdata act=%h exp=%h at %0t", cur_req, rdata, e_rdata, $time);
      end
    end
  end

  function automatic bit [7:0] grp_a(input int p); return 8'(4*p); endfunction
  function automatic bit [7:0] ctl_a(input int c); return 8'(128 + 8*c); endfunction
  function automatic bit [7:0] per_a(input int c); return 8'(132 + 8*c); endfunction

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 8'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); addr = 8'($urandom); end
  endtask

  task automatic rand_write();
    int kind = int'($urandom % 5);
    int idx  = int'($urandom % NCH);
    bit [31:0] d;
    bit [7:0]  a;
    case (kind)
      0: begin a = grp_a(idx % NGRP); d = (32'($urandom % 2) << 4) | 32'($urandom % 4); end
      1: begin a = 8'h40; d = 32'($urandom % 256); end
      2: begin a = 8'h44; d = 32'($urandom % 256); end
      3: begin a = ctl_a(idx); d = (32'($urandom % 2) << 8) | 32'($urandom % 4); end
      default: begin a = per_a(idx); d = (32'($urandom % 16) << 16) | 32'($urandom % 19); end
    endcase
    if ($urandom % 12 == 0) d = $urandom;
    wr(a, d);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL R11 watchdog act=running exp=finished at %0t", $time);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd90417));
    // R1: reset state
    cur_req = "R1";
    @(posedge clk); checking = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(5);

    // R2: write every register, then sweep all offsets for read-back and zeros
    cur_req = "R2";
    for (int p = 0; p < NGRP; p++) wr(grp_a(p), $urandom);
    for (int c = 0; c < NCH; c++) begin wr(ctl_a(c), $urandom); wr(per_a(c), $urandom); end
    wr(8'h44, $urandom);
    for (int a = 0; a < 256; a++) begin @(negedge clk); addr = 8'(a); end
    for (int p = 0; p < NGRP; p++) wr(grp_a(p), 0);
    for (int c = 0; c < NCH; c++) begin wr(ctl_a(c), 0); wr(per_a(c), 0); end
    wr(8'h44, 0);

    // R3: source choice and power-of-two division shared by a pair
    cur_req = "R3";
    wr(grp_a(0), 32'h0);
    wr(ctl_a(0), 32'h100);
    wr(per_a(0), (32'd4 << 16) | 32'd2);
    wr(ctl_a(1), 32'h100);
    wr(per_a(1), (32'd3 << 16) | 32'd1);
    wr(8'h44, 32'h03);
    wr(8'h40, 32'h03);
    idle(60);
    wr(grp_a(0), 32'h2);
    idle(120);
    osc_pct = 30;
    wr(grp_a(0), 32'h12);
    idle(120);
    wr(grp_a(0), 32'h10);

    // R4: prescaler
    cur_req = "R4";
    wr(ctl_a(0), 32'h103);
    idle(150);
    wr(ctl_a(0), 32'h100);

    // R5: period wrap and active phase, including entire count of zero
    cur_req = "R5";
    wr(per_a(0), (32'd9 << 16) | 32'd3);
    idle(120);
    wr(per_a(0), 32'h0);
    idle(20);

    // R6: full and zero duty
    cur_req = "R6";
    wr(per_a(0), (32'd6 << 16) | 32'd7);
    idle(60);
    wr(per_a(0), (32'd6 << 16) | 32'd6);
    idle(60);
    wr(per_a(0), (32'd6 << 16) | 32'd0);
    idle(40);
    wr(per_a(0), (32'd6 << 16) | 32'hFFFF);
    idle(40);

    // R7: inverted active level
    cur_req = "R7";
    wr(ctl_a(0), 32'h000);
    wr(per_a(0), (32'd5 << 16) | 32'd2);
    idle(80);

    // R8: gate clear freezes the channel
    cur_req = "R8";
    wr(8'h44, 32'h02);
    idle(40);
    wr(8'h44, 32'h03);
    idle(40);

    // R10: shrink the period while the count is well past the new end
    cur_req = "R10";
    wr(ctl_a(0), 32'h100);
    wr(per_a(0), (32'd30 << 16) | 32'd10);
    idle(25);
    wr(per_a(0), (32'd5 << 16) | 32'd3);
    idle(40);

    // R9: disable tri-states and restarts from the active phase
    cur_req = "R9";
    wr(8'h40, 32'h02);
    idle(20);
    wr(8'h40, 32'h03);
    idle(30);

    // R1: reset in mid-operation
    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(5);

    // R11: seeded random writes with random tick densities
    cur_req = "R11";
    for (int it = 0; it < 400; it++) begin
      if (it % 50 == 0) begin
        osc_pct = int'($urandom % 101);
        bus_pct = int'($urandom % 101);
      end
      rand_write();
      idle(1 + int'($urandom % 40));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule